// File: doc/BRIEF.md
# I2C Byte Master

This block is an I2C bus master that a host runs one byte at a time. The host talks to three registers: a data buffer at address 0, a control register at address 1 and a status register at address 2. To move one byte, the host writes the control register with its transfer bit set. Other control bits chosen with that write decide what surrounds the byte:

- a START (or repeated START) before it;
- a STOP after it;
- on a received byte, a NACK in place of an ACK.

When the byte completes, hardware clears the transfer bit. If no STOP was asked for, the bus stays held with SCL low until the host gives the next instruction.

The block drives SCL directly. SDA is handled open-drain style: an output enable pulls the line low, and the resolved line comes back on an input. One bus bit takes four quarter periods, and each quarter lasts `QDIV` clock cycles, so SCL is high for half of every bit. After an address byte whose lowest bit is 1 is acknowledged, the block switches to receiving. The abort bit lets the host release a held bus with a STOP alone, without clocking any byte.

Control register bits: [0] transfer, [1] start, [2] stop, [3] nack, [4] abort, [5] receive interrupt enable, [6] transmit interrupt enable.
Status register bits: [0] ack/nack of the last byte (1 = NACK), [1] receive full, [2] transmit empty, [3] unit busy, [4] receive mode.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, SCL is high, SDA is released, the control and status registers read 0, and both interrupt outputs are low.
- R2: With the start bit set, or when the bus is idle, a transfer begins with SDA falling while SCL is high. Within a byte, SDA changes only while SCL is low. A STOP is SDA rising while SCL is high.
- R3: When transmitting, the data buffer goes out MSB first. On the ninth clock the level of SDA is sampled into status[0]. At the end of the byte, status[2] is set and control[0] is cleared.
- R4: An acknowledged address byte with bit 0 = 1 sets status[4]. An address with bit 0 = 0, or a NACKed address, leaves status[4] clear. status[4] is cleared after a STOP.
- R5: When receiving, eight bits are shifted in MSB first and loaded into the data buffer, and status[1] is set. During the ninth clock the block drives SDA low if control[3] is 0 and releases it if control[3] is 1. status[0] then shows control[3].
- R6: If control[2] is set, a STOP follows the byte. status[3] stays 1 until the STOP is complete, and the bus is released afterwards.
- R7: If control[2] is clear, the bus is held after the byte with SCL low and no STOP. Writing start and transfer then produces a repeated START.
- R8: Writing control with abort set and transfer clear while the bus is held issues only a STOP, with a single SCL rise. The abort bit is then cleared.
- R9: Each interrupt output equals its status flag ANDed with its enable bit. Writing 1 to status[1] or status[2] clears that flag. Writing 0 to a flag leaves it unchanged.
- R10: During a data bit, SCL is high for 2*QDIV and low for 2*QDIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| scl_o | output | 1 | Bus clock |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Resolved SDA line level |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_tx | output | 1 | Transmit-empty interrupt |

## Verification
A model slave with a fixed address answers in three patterns:

- an addressed write of a two-byte stream, ended by a STOP;
- a write, then a repeated-START read of two bytes, where the first is ACKed and the last is NACKed;
- a mis-addressed byte that the slave leaves unacknowledged, followed by an abort.

The write pattern shows whether bits leave MSB first and whether SCL keeps its duty cycle. The read pattern shows whether the switch to receive mode happens and whether the master drives the right ACK or NACK level. The NACK pattern shows that a held bus is released with a STOP alone and no further clocking.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_START, ST_BIT, ST_STOP} eng_state_t;

  // control register bits
  localparam int CB_XFER  = 0;
  localparam int CB_START = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_NACK  = 3;
  localparam int CB_ABORT = 4;
  localparam int CB_RXIE  = 5;
  localparam int CB_TXIE  = 6;

  // status register bits
  localparam int SB_ACKNAK  = 0;
  localparam int SB_RXFULL  = 1;
  localparam int SB_TXEMPTY = 2;
  localparam int SB_BUSY    = 3;
  localparam int SB_RXMODE  = 4;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
endpackage

// File: rtl/i2c_bm_qtick.sv
module i2c_bm_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (QDIV > 1) begin : g_tick_chk
      // R10: quarter ticks are single pulses spaced by the divider
      assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic              abort,
  input  logic              want_start,
  input  logic              want_stop,
  input  logic              want_nack,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              done,
  output logic              done_rx,
  output logic              ack_nak,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              rx_mode,
  output logic              stop_done
);
  localparam int CNTW = $clog2(BYTE_W + 1);
  localparam logic [CNTW-1:0] LASTBIT = CNTW'(BYTE_W);

  eng_state_t        state;
  logic [1:0]        qph;
  logic [CNTW-1:0]   bitn;
  logic [BYTE_W-1:0] shreg;
  logic              scl_q, sda_q;
  logic              is_rx, is_addr, rw_bit, stop_after, nack_sel;

  always_ff @(posedge clk) begin
    done      <= 1'b0;
    stop_done <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      qph        <= 2'd0;
      bitn       <= '0;
      shreg      <= '0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b0;
      is_rx      <= 1'b0;
      is_addr    <= 1'b0;
      rw_bit     <= 1'b0;
      stop_after <= 1'b0;
      nack_sel   <= 1'b0;
      ack_nak    <= 1'b0;
      rx_mode    <= 1'b0;
      done_rx    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          qph  <= 2'd0;
          bitn <= '0;
          if (go) begin
            shreg      <= tx_byte;
            stop_after <= want_stop;
            nack_sel   <= want_nack;
            if (want_start || state == ST_IDLE) begin
              is_addr <= 1'b1;
              is_rx   <= 1'b0;
              rw_bit  <= tx_byte[0];
              state   <= ST_START;
            end else begin
              is_addr <= 1'b0;
              is_rx   <= rx_mode;
              state   <= ST_BIT;
            end
          end else if (abort && state == ST_HOLD) begin
            state <= ST_STOP;
          end
        end
        ST_START: if (tick) begin
          qph <= qph + 2'd1;
          case (qph)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b1;
            default: begin
              scl_q <= 1'b0;
              state <= ST_BIT;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          qph <= qph + 2'd1;
          case (qph)
            2'd0: begin
              if (bitn < LASTBIT) sda_q <= is_rx ? 1'b0 : !shreg[BYTE_W-1];
              else                sda_q <= is_rx ? !nack_sel : 1'b0;
            end
            2'd1: scl_q <= 1'b1;
            2'd2: begin
              if (bitn < LASTBIT) shreg   <= {shreg[BYTE_W-2:0], sda_i};
              else                ack_nak <= is_rx ? nack_sel : sda_i;
            end
            default: begin
              scl_q <= 1'b0;
              if (bitn < LASTBIT) begin
                bitn <= bitn + 1'b1;
              end else begin
                done    <= 1'b1;
                done_rx <= is_rx;
                sda_q   <= stop_after;
                if (is_addr) rx_mode <= rw_bit & !ack_nak;
                state   <= stop_after ? ST_STOP : ST_HOLD;
              end
            end
          endcase
        end
        ST_STOP: if (tick) begin
          qph <= qph + 2'd1;
          case (qph)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b0;
            default: begin
              state     <= ST_IDLE;
              rx_mode   <= 1'b0;
              stop_done <= 1'b1;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scl_o   = scl_q;
  assign sda_oe  = sda_q;
  assign rx_byte = shreg;
  assign busy    = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);

  // R2: inside a byte SDA never moves while SCL stays high
  assert_sda_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT && $past(state) == ST_BIT && scl_q && $past(scl_q))
      |-> (sda_q == $past(sda_q)));

  // R7: a held bus keeps SCL low with SDA released
  assert_hold_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (!scl_q && !sda_q));

  // R6: once the STOP is through, the bus is released
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (scl_q && !sda_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              scl_o,
  output logic              sda_oe,
  input  logic              sda_i,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'((1 << (CB_TXIE + 1)) - 1);

  logic [BYTE_W-1:0] data_q, ctrl_q, rx_byte, stat_w;
  logic go_q, rx_full_q, tx_empty_q;
  logic tick, done, done_rx, ack_nak, busy, rx_mode, stop_done;

  i2c_bm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk(clk), .rst(rst), .en(busy), .tick(tick)
  );

  i2c_bm_engine u_engine (
    .clk(clk), .rst(rst), .tick(tick), .go(go_q),
    .abort(ctrl_q[CB_ABORT] & ~ctrl_q[CB_XFER]),
    .want_start(ctrl_q[CB_START]), .want_stop(ctrl_q[CB_STOP]),
    .want_nack(ctrl_q[CB_NACK]), .tx_byte(data_q), .sda_i(sda_i),
    .scl_o(scl_o), .sda_oe(sda_oe), .done(done), .done_rx(done_rx),
    .ack_nak(ack_nak), .rx_byte(rx_byte), .busy(busy), .rx_mode(rx_mode),
    .stop_done(stop_done)
  );

  always_comb begin
    stat_w             = '0;
    stat_w[SB_ACKNAK]  = ack_nak;
    stat_w[SB_RXFULL]  = rx_full_q;
    stat_w[SB_TXEMPTY] = tx_empty_q;
    stat_w[SB_BUSY]    = busy;
    stat_w[SB_RXMODE]  = rx_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      ctrl_q     <= '0;
      go_q       <= 1'b0;
      rx_full_q  <= 1'b0;
      tx_empty_q <= 1'b0;
      irq_rx     <= 1'b0;
      irq_tx     <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      go_q <= 1'b0;
      if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
      if (reg_wr && reg_addr == RA_CTRL) begin
        ctrl_q <= reg_wdata & CTRL_MASK;
        go_q   <= reg_wdata[CB_XFER];
      end
      if (reg_wr && reg_addr == RA_STAT) begin
        if (reg_wdata[SB_RXFULL])  rx_full_q  <= 1'b0;
        if (reg_wdata[SB_TXEMPTY]) tx_empty_q <= 1'b0;
      end
      if (done) begin
        ctrl_q[CB_XFER] <= 1'b0;
        if (done_rx) begin
          data_q    <= rx_byte;
          rx_full_q <= 1'b1;
        end else begin
          tx_empty_q <= 1'b1;
        end
      end
      if (stop_done) ctrl_q[CB_ABORT] <= 1'b0;
      irq_rx <= rx_full_q & ctrl_q[CB_RXIE];
      irq_tx <= tx_empty_q & ctrl_q[CB_TXIE];
      case (reg_addr)
        RA_DATA: reg_rdata <= data_q;
        RA_CTRL: reg_rdata <= ctrl_q;
        RA_STAT: reg_rdata <= stat_w;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R3: a finished byte hands the transfer bit back to the host
  assert_xfer_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !reg_wr) |=> !ctrl_q[CB_XFER]);

  // R5: a received byte raises receive-full
  assert_rx_full_R5: assert property (@(posedge clk) disable iff (rst)
    (done && done_rx) |=> rx_full_q);
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
  localparam int QDIV = 4;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, reg_wr, scl_o, sda_oe, irq_rx, irq_tx;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       slv_low = 1'b0;
  wire        sda_line = !(sda_oe | slv_low);

  i2c_byte_master #(.QDIV(QDIV)) i_i2c_byte_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_o(scl_o),
    .sda_oe(sda_oe), .sda_i(sda_line), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int n_chk = 0, n_fail = 0;
  int starts = 0, stops = 0, rises = 0;

  // model slave
  int         s_bitcnt = 0, rd_idx = 0, wr_cnt = 0, mack_cnt = 0;
  logic       s_is_addr = 0, s_rw = 0, s_match = 0, s_skip = 0, s_last_mack = 1;
  logic [7:0] s_shift = 0, s_tx = 0;
  logic [7:0] wr_log [0:7];
  logic       mack_log [0:7];

  function automatic logic [7:0] rd_byte(int idx);
    return (idx == 0) ? 8'hC3 : 8'h5A;
  endfunction

  initial forever begin
    @(negedge sda_line);
    if (scl_o === 1'b1) begin
      starts++; s_bitcnt = 0; s_is_addr = 1; s_skip = 1; slv_low = 0;
    end
  end
  initial forever begin
    @(posedge sda_line);
    if (scl_o === 1'b1) stops++;
  end
  initial forever begin
    @(posedge scl_o);
    rises++;
    if (s_bitcnt < 8) s_shift = {s_shift[6:0], sda_line};
    else if (s_rw && !s_is_addr && s_match) begin
      s_last_mack = sda_line;
      if (mack_cnt < 8) mack_log[mack_cnt] = sda_line;
      mack_cnt++;
    end
  end
  initial forever begin
    @(negedge scl_o);
    if (s_skip) s_skip = 0;
    else begin
      s_bitcnt++;
      if (s_bitcnt == 8) begin
        if (s_is_addr) begin
          s_rw = s_shift[0]; s_match = (s_shift[7:1] == SLV); slv_low = s_match;
        end else if (!s_rw && s_match) begin
          if (wr_cnt < 8) wr_log[wr_cnt] = s_shift;
          wr_cnt++; slv_low = 1;
        end else slv_low = 0;
      end else if (s_bitcnt == 9) begin
        s_bitcnt = 0;
        if (s_is_addr) begin
          s_is_addr = 0;
          if (s_rw && s_match) begin s_tx = rd_byte(rd_idx); slv_low = !s_tx[7]; end
          else slv_low = 0;
        end else if (s_rw && s_match && !s_last_mack) begin
          rd_idx++; s_tx = rd_byte(rd_idx); slv_low = !s_tx[7];
        end else slv_low = 0;
      end else if (s_rw && !s_is_addr && s_match) slv_low = !s_tx[7 - s_bitcnt];
      else slv_low = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_byte(string req);
    logic [7:0] v;
    logic ok = 0;
    for (int i = 0; i < 3000; i++) begin
      host_rd(2'd1, v);
      if (!v[0]) begin ok = 1; break; end
    end
    check(req, ok, 1, "transfer bit cleared by hardware");
  endtask

  task automatic wait_idle(string req);
    logic [7:0] v;
    logic ok = 0;
    for (int i = 0; i < 3000; i++) begin
      host_rd(2'd2, v);
      if (!v[3]) begin ok = 1; break; end
    end
    check(req, ok, 1, "busy cleared");
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1", scl_o, 1, "scl after reset");
    check("R1", sda_oe, 0, "sda released after reset");
    check("R1", {irq_rx, irq_tx}, 0, "irqs after reset");
    host_rd(2'd2, v); check("R1", v, 0, "status after reset");
    host_rd(2'd1, v); check("R1", v, 0, "control after reset");
  endtask

  task automatic t_write;
    logic [7:0] v;
    int hi = 0, lo = 0;
    host_wr(2'd0, {SLV, 1'b0});
    host_wr(2'd1, 8'h43);            // TXIE | START | XFER
    wait_byte("R3");
    check("R2", starts, 1, "start count");
    host_rd(2'd2, v);
    check("R3", v[0], 0, "address acked");
    check("R3", v[2], 1, "tx empty set");
    check("R4", v[4], 0, "write address keeps tx mode");
    check("R7", {scl_o, sda_oe}, 2'b00, "bus held after byte");
    check("R9", irq_tx, 1, "tx irq enabled");
    host_wr(2'd2, 8'h04);
    repeat (3) @(negedge clk);
    check("R9", irq_tx, 0, "tx irq after w1c");
    host_wr(2'd0, 8'hA5);
    host_wr(2'd1, 8'h01);
    @(posedge scl_o); @(posedge scl_o); @(posedge scl_o);
    @(negedge clk);
    while (scl_o) begin hi++; @(negedge clk); end
    while (!scl_o) begin lo++; @(negedge clk); end
    check("R10", hi, 2 * QDIV, "scl high cycles");
    check("R10", lo, 2 * QDIV, "scl low cycles");
    wait_byte("R3");
    host_wr(2'd0, 8'h3C);
    host_wr(2'd1, 8'h05);            // STOP | XFER
    wait_byte("R6");
    host_rd(2'd2, v);
    check("R6", v[3], 1, "busy held during stop");
    wait_idle("R6");
    check("R6", stops, 1, "stop count");
    check("R3", wr_log[0], 8'hA5, "first written byte");
    check("R3", wr_log[1], 8'h3C, "second written byte");
    check("R6", {scl_o, sda_oe}, 2'b10, "bus released");
  endtask

  task automatic t_read;
    logic [7:0] v;
    host_wr(2'd0, {SLV, 1'b0});
    host_wr(2'd1, 8'h03);
    wait_byte("R3");
    host_wr(2'd0, 8'h11);
    host_wr(2'd1, 8'h01);
    wait_byte("R3");
    check("R3", wr_log[2], 8'h11, "byte before repeated start");
    host_wr(2'd0, {SLV, 1'b1});
    host_wr(2'd1, 8'h03);
    wait_byte("R7");
    check("R7", starts, 3, "repeated start issued");
    check("R7", stops, 1, "no stop before repeated start");
    host_rd(2'd2, v);
    check("R4", v[4], 1, "read address enters rx mode");
    host_wr(2'd1, 8'h21);            // RXIE | XFER, ack
    wait_byte("R5");
    host_rd(2'd0, v); check("R5", v, 8'hC3, "first read byte");
    host_rd(2'd2, v); check("R5", v[1], 1, "rx full set");
    check("R9", irq_rx, 1, "rx irq enabled");
    check("R5", mack_log[0], 0, "master acked first byte");
    host_wr(2'd2, 8'h02);
    host_rd(2'd2, v);
    check("R9", v[1], 0, "rx full cleared by w1c");
    check("R9", v[2], 1, "tx empty untouched by zero write");
    host_wr(2'd1, 8'h2D);            // RXIE | NACK | STOP | XFER
    wait_byte("R5");
    host_rd(2'd0, v); check("R5", v, 8'h5A, "last read byte");
    host_rd(2'd2, v); check("R5", v[0], 1, "nack reflected in status");
    check("R5", mack_log[1], 1, "master released sda for nack");
    wait_idle("R6");
    check("R6", stops, 2, "stop after nack");
    host_rd(2'd2, v); check("R4", v[4], 0, "rx mode cleared after stop");
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int r0;
    host_wr(2'd0, {7'h33, 1'b0});
    host_wr(2'd1, 8'h03);
    wait_byte("R3");
    host_rd(2'd2, v);
    check("R3", v[0], 1, "unmatched address nacked");
    check("R4", v[4], 0, "no rx mode on nack");
    r0 = rises;
    host_wr(2'd1, 8'h10);            // ABORT only
    repeat (60) @(negedge clk);
    check("R8", stops, 3, "abort issued stop");
    check("R8", rises - r0, 1, "single scl rise on abort");
    host_rd(2'd1, v); check("R8", v[4], 0, "abort bit cleared");
    check("R8", {scl_o, sda_oe}, 2'b10, "bus released after abort");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    starts = 0; stops = 0; rises = 0; s_bitcnt = 0; s_skip = 0;
    t_reset;
    t_write;
    t_read;
    t_abort;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule